// File: doc/BRIEF.md
# PCI Host Bridge Interrupt Pending/Enable Register

This block is the single 32-bit interrupt word of a PCI host bridge. Its low half carries pending flags for ten sources: the four legacy level-sensitive interrupt lines A to D, and six bus-error events. Its upper half carries one enable bit per source, placed 16 positions above that source's pending flag. A source counts as active only when its pending flag and its enable bit are both set. All active sources merge into one registered request line to the system interrupt controller. The per-source qualified flags are also brought out, so that a handler can dispatch without decoding the word.

The legacy lines are active-low levels. They pass through a synchronizer, and each pending flag simply follows its line. Error events arrive as one-cycle pulses from the bridge's error detection. Each pulse sets a sticky flag, and software clears that flag by writing 1 to its position. Every write also loads the enable field. A write of the all-zero word is a full shutdown: it disables every source and drops every sticky error flag. A parameter chooses the enables loaded at reset. The narrow default set enables only the abort events. The full set adds the parity and system-error events.

Top module: `pci_irq_ctrl`

## Requirements
- R1: After reset, the register reads 0x00E0_0000 with FULL_ERR_SET=0 (enables at bits 21–23 only) or 0x03F0_0000 with FULL_ERR_SET=1 (enables at bits 20–25), and both irq_out and src_active are zero.
- R2: Bits 0–3 show INTA..INTD pending, each equal to the inverse of intx_n[0..3]. A change on intx_n appears there on the second rising edge after it is applied, and not on the first.
- R3: A high err_evt[k] (k=0..5) sets sticky pending bit 4+k on the next rising edge: bit 4 data parity detected, bit 5 signalled target abort, bit 6 received target abort, bit 7 received master abort, bit 8 signalled system error, bit 9 detected parity. The bit then stays set until it is cleared.
- R4: A write with bit 4+k set clears error pending bit 4+k. Error bits written as 0 keep their value.
- R5: A write of the all-zero word clears every enable bit and every error pending bit. The INTx bits keep following their inputs.
- R6: When an error event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Every write loads wdata[25:16] into the enable bits, where bit 16+n enables source n, and the enable bits read back unchanged.
- R8: src_active[n] equals pending bit n AND enable bit 16+n in the same cycle that the register shows them. irq_out is the OR of src_active, delayed by one clock.
- R9: Bits 10–15 and 26–31 always read as zero, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the interrupt word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current interrupt word |
| intx_n | input | 4 | Legacy interrupt lines A..D, active low, asynchronous |
| err_evt | input | 6 | One-cycle bus-error event pulses |
| src_active | output | 10 | Pending AND enabled, per source |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The block's results fall due at three different delays. A line change on intx_n shows in the word two rising edges later, so the bench samples once after the first edge to see the old value and once after the second to see the new one. Error events, clears and enable writes take effect on the next edge, and the bench reads the word and src_active at the falling edge right after that edge. irq_out trails src_active by one more edge and is sampled one falling edge later. All inputs change at falling edges.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_INTX  = 4;
  localparam int NUM_ERR   = 6;
  localparam int NUM_SRC   = NUM_INTX + NUM_ERR;
  localparam int MASK_BASE = 16;
  localparam int RSV_LO_W  = MASK_BASE - NUM_SRC;
  localparam int RSV_HI_W  = REG_W - MASK_BASE - NUM_SRC;

  // Source index of the first and last abort events in the narrow default set
  localparam int ABORT_FIRST = 5;
  localparam int ABORT_LAST  = 7;

  function automatic logic [NUM_SRC-1:0] default_mask(input logic full_set);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (full_set && i >= NUM_INTX) m[i] = 1'b1;
      if (i >= ABORT_FIRST && i <= ABORT_LAST) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NUM_SRC-1:0] qualify(input logic [NUM_SRC-1:0] pend,
                                                 input logic [NUM_SRC-1:0] mask);
    return pend & mask;
  endfunction

  function automatic logic [NUM_ERR-1:0] err_clear(input logic wr,
                                                   input logic [REG_W-1:0] wdata);
    if (!wr) return '0;
    if (wdata == '0) return '1;
    return wdata[NUM_INTX +: NUM_ERR];
  endfunction
endpackage

// File: rtl/pci_irq_sync.sv
module pci_irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pci_irq_err_bank.sv
module pci_irq_err_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_evt,
  input  logic [W-1:0] clr_req,
  output logic [W-1:0] pend
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend[i] <= 1'b0;
      else if (set_evt[i])  pend[i] <= 1'b1;
      else if (clr_req[i])  pend[i] <= 1'b0;
    end

    // R3 / R6: an event always leaves the bit set, even under a clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> pend[i]);
    // R4: a clear without an event drops the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_evt[i]) |=> !pend[i]);
    // R3: sticky when untouched
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req[i] && !set_evt[i]) |=> $stable(pend[i]));
  end
endmodule

// File: rtl/pci_irq_ctrl.sv
module pci_irq_ctrl
  import pci_irq_pkg::*;
#(
  parameter logic FULL_ERR_SET = 1'b0,
  parameter int   SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_INTX-1:0] intx_n,
  input  logic [NUM_ERR-1:0]  err_evt,
  output logic [NUM_SRC-1:0]  src_active,
  output logic               irq_out
);
  localparam logic [NUM_SRC-1:0] MASK_RST = default_mask(FULL_ERR_SET);

  logic [NUM_INTX-1:0] intx_lvl_n;
  logic [NUM_INTX-1:0] intx_pend;
  logic [NUM_ERR-1:0]  err_pend;
  logic [NUM_ERR-1:0]  err_clr;
  logic [NUM_SRC-1:0]  mask_q;
  logic [NUM_SRC-1:0]  pend_all;
  logic                any_active;
  logic                irq_q;

  pci_irq_sync #(.W(NUM_INTX), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (intx_n),
    .q_sync  (intx_lvl_n)
  );

  assign intx_pend = ~intx_lvl_n;
  assign err_clr   = err_clear(reg_wr, reg_wdata);

  pci_irq_err_bank #(.W(NUM_ERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (err_evt),
    .clr_req (err_clr),
    .pend    (err_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= MASK_RST;
    else if (reg_wr) mask_q <= reg_wdata[MASK_BASE +: NUM_SRC];
  end

  assign pend_all   = {err_pend, intx_pend};
  assign src_active = qualify(pend_all, mask_q);
  assign any_active = |src_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_active;
  end

  assign irq_out   = irq_q;
  assign reg_rdata = {{RSV_HI_W{1'b0}}, mask_q, {RSV_LO_W{1'b0}}, pend_all};

  // R8: combined request follows the qualified sources one clock later
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |=> irq_out);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |=> !irq_out);
  // R7: enable field loads from every write
  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[MASK_BASE +: NUM_SRC] == $past(reg_wdata[MASK_BASE +: NUM_SRC])));
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(mask_q));
  // R5: zero word shuts every error flag unless an event arrives with it
  p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata == '0 && err_evt == '0) |=> (err_pend == '0));
endmodule

// File: tb/pci_irq_ctrl_tb.sv
module pci_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_n = 4'hF;
  logic [5:0]  err_evt = '0;
  logic [9:0]  src_active;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .intx_n(intx_n), .err_evt(err_evt),
    .src_active(src_active), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] expm;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state, narrow default enable set (bits 21..23)
    chk("R1 rdata", reg_rdata, 32'h00E0_0000);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 active", {22'b0, src_active}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R9: reserved bits read zero; R7 all enables set
    reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    tick();
    reg_wr = 1'b0;
    chk("R9 reserved zero", reg_rdata, 32'h03FF_0000);

    // R2 / R8: sweep all INTx patterns
    for (int v = 0; v < 16; v++) begin
      logic [3:0] prev;
      prev = reg_rdata[3:0];
      intx_n = ~v[3:0];
      tick();
      chk("R2 not yet", {28'b0, reg_rdata[3:0]}, {28'b0, prev});
      tick();
      chk("R2 pending", {28'b0, reg_rdata[3:0]}, {28'b0, v[3:0]});
      chk("R8 active intx", {22'b0, src_active}, {28'b0, v[3:0]});
      tick();
      chk("R8 irq intx", {31'b0, irq_out}, {31'b0, (v != 0)});
    end

    // R3 / R4: each error event sets its sticky bit, W1C clears it
    for (int i = 0; i < 6; i++) begin
      err_evt = 6'(1 << i);
      tick();
      err_evt = '0;
      chk("R3 set", {26'b0, reg_rdata[9:4]}, 32'(1 << i));
      tick();
      chk("R3 sticky", {26'b0, reg_rdata[9:4]}, 32'(1 << i));
      reg_wr = 1'b1; reg_wdata = 32'h03FF_0000 | 32'(1 << (4 + i));
      tick();
      reg_wr = 1'b0;
      chk("R4 clear", {26'b0, reg_rdata[9:4]}, 32'h0);
    end

    // R4: writing 0 to an error bit keeps it
    err_evt = 6'h3F;
    tick();
    err_evt = '0;
    reg_wr = 1'b1; reg_wdata = 32'h03FF_0020;
    tick();
    reg_wr = 1'b0;
    chk("R4 partial", {26'b0, reg_rdata[9:4]}, 32'h3D);

    // R7 / R8: sweep every enable pattern with all sources pending
    for (int m = 0; m < 1024; m++) begin
      expm = m[9:0];
      reg_wr = 1'b1; reg_wdata = {6'b0, expm, 16'b0}; err_evt = 6'h3F;
      tick();
      reg_wr = 1'b0; err_evt = '0;
      chk("R7 readback", reg_rdata, {6'b0, expm, 16'h03FF});
      chk("R8 active", {22'b0, src_active}, {22'b0, expm});
      tick();
      chk("R8 irq", {31'b0, irq_out}, {31'b0, (m != 0)});
    end

    // R6: set and clear of bit 4 in the same cycle
    reg_wr = 1'b1; reg_wdata = 32'h03FF_0010; err_evt = 6'h01;
    tick();
    reg_wr = 1'b0; err_evt = '0;
    chk("R6 set wins", {26'b0, reg_rdata[9:4]}, 32'h3F);

    // R5: zero word clears enables and errors, INTx still follows
    reg_wr = 1'b1; reg_wdata = 32'h0;
    tick();
    reg_wr = 1'b0;
    chk("R5 zero write", reg_rdata, 32'h0000_000F);
    chk("R5 active", {22'b0, src_active}, 32'h0);
    tick();
    chk("R5 irq", {31'b0, irq_out}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule